// File: doc/BRIEF.md
# Multi-Channel Execution Span Profiler

The block watches up to NCH hardware modules through two strobes each: one that pulses when a module begins an invocation and one that pulses when it finishes. All channels share a single free-running 48-bit cycle counter, which provides a common time base. When a span closes, the block builds a record that carries the channel number, the invocation index for that channel, and the counter values sampled on the opening and closing strobes. The record goes into a small buffer for that channel.

A single valid/ready stream drains the buffers to an outside collector and serves the channels in round-robin order. For each channel the block also keeps a running sum of span lengths, which lets the busiest modules be ranked once a run is over. The block only observes. It has no path back to the watched modules, so a full buffer causes records to be dropped and never stalls anything. A synchronous clear input returns the profiler to its post-reset state. A parameter chooses the buffer style: a memory with registered read, suited to block RAM, or a plain register array. Both styles produce the same records in the same order.

Top module: `span_profiler`

## Requirements
- R1: After reset or clear the cycle counter reads 0 in the first cycle and then rises by one each cycle, wrapping modulo 2^48. A strobe sampled in a given cycle is stamped with the counter value of that cycle, so a start pulse in the cycle right after clear is stamped 0.
- R2: When a channel sees a done pulse while its span is open, the block emits one record. The record holds the channel number on `rec_chan`, an invocation index on `rec_iter` that counts closed spans of that channel from 0, the opening timestamp on `rec_t_start` and the closing timestamp on `rec_t_end`.
- R3: A span that closes while its channel already holds DEPTH buffered records is discarded. Bit i of `ovf_flags` then goes to 1 and stays at 1 until clear. The channel's running total still includes the discarded span's length.
- R4: A start pulse while a span is open and no done pulse arrives in the same cycle restarts the span at the new timestamp and raises that channel's error count by one. The count saturates at its maximum.
- R5: A done pulse on a channel with no open span produces no record and leaves the invocation index unchanged.
- R6: While `rec_valid` is high and `rec_ready` is low, `rec_valid` and all record fields hold their values.
- R7: Channels with pending records take turns in round-robin order. After a channel is served, the next channel above it has priority. After reset or clear, channel 0 has priority.
- R8: Driving a channel number on `stat_sel` makes that channel's running total of (end − start) appear on `stat_total`, and its error count on `stat_errs`, two clock edges later.
- R9: A clear pulse empties every buffer and the output stage, and zeroes the counter, the invocation indices, the totals, the error counts and `ovf_flags`, all in one cycle.
- R10: The block-RAM buffer style and the register buffer style deliver the same record contents in the same per-channel order.
- R11: A start and a done pulse in the same cycle on an open channel close the current span and immediately open a new one with the same timestamp. This does not count as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of all profiling state |
| start_i | input | NCH | Per-channel invocation start strobes |
| done_i | input | NCH | Per-channel invocation done strobes |
| rec_valid | output | 1 | Record available on the stream |
| rec_ready | input | 1 | Collector accepts the record |
| rec_chan | output | CH_W | Channel number of the record |
| rec_iter | output | 16 | Invocation index of the record |
| rec_t_start | output | 48 | Opening timestamp |
| rec_t_end | output | 48 | Closing timestamp |
| stat_sel | input | CH_W | Channel selected for the statistics read |
| stat_total | output | TOT_W | Running active-cycle total of the selected channel |
| stat_errs | output | ERR_W | Restart error count of the selected channel |
| ovf_flags | output | NCH | Sticky per-channel overflow flags |

## Verification
If a channel's open-span state or invocation counter goes wrong, the next record from that channel shows it: a span is missing or extra, `rec_iter` skips or repeats, or the timestamps do not match the strobe times. This is visible at most a few cycles after the done pulse. If a buffer pointer or occupancy count is corrupted, records come out duplicated, lost or reordered. The same fault also shows up as `ovf_flags` being set too early or too late against a known fill sequence. A fault in the arbiter pointer changes the channel order on the stream while it drains. A fault in the accumulators appears on `stat_total` two edges after that channel is selected.

// File: rtl/span_prof_pkg.sv
package span_prof_pkg;
  localparam int TS_W   = 48;
  localparam int ITER_W = 16;

  typedef struct packed {
    logic [ITER_W-1:0] iter;
    logic [TS_W-1:0]   t_start;
    logic [TS_W-1:0]   t_end;
  } span_rec_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sp_timebase.sv
module sp_timebase
  import span_prof_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  output logic [TS_W-1:0] now
);
  // free-running shared time base, wraps silently
  always_ff @(posedge clk) begin
    if (rst || clr) now <= '0;
    else            now <= now + 1'b1;
  end
endmodule

// File: rtl/sp_fifo.sv
module sp_fifo
  import span_prof_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit USE_BRAM = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      wr_en,
  input  span_rec_t wr_data,
  output logic      full,
  input  logic      rd_en,
  output logic      rd_valid,
  output span_rec_t rd_data
);
  localparam int AW = idx_w(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  span_rec_t         mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [OW-1:0]     occ;
  logic              push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (occ == OW'(DEPTH));
  assign push = wr_en && !full;

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  wptr <= '0;
    else if (push)   wptr <= nxt(wptr);
  end

  generate
    if (USE_BRAM) begin : g_ram
      // registered read into a show-ahead stage
      logic [OW-1:0] mem_cnt;
      logic          stage_v;
      span_rec_t     stage_d;
      logic          load;

      assign load     = (mem_cnt != '0) && (!stage_v || rd_en);
      assign occ      = mem_cnt + OW'(stage_v);
      assign rd_valid = stage_v;
      assign rd_data  = stage_d;

      always_ff @(posedge clk) begin
        if (load) stage_d <= mem[rptr];
      end

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          stage_v <= 1'b0;
          mem_cnt <= '0;
          rptr    <= '0;
        end else begin
          if (load)       stage_v <= 1'b1;
          else if (rd_en) stage_v <= 1'b0;
          mem_cnt <= mem_cnt + OW'(push) - OW'(load);
          if (load) rptr <= nxt(rptr);
        end
      end
    end else begin : g_reg
      // register array with combinational head
      logic [OW-1:0] cnt;
      logic          pop;

      assign occ      = cnt;
      assign rd_valid = (cnt != '0);
      assign rd_data  = mem[rptr];
      assign pop      = rd_en && rd_valid;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          cnt  <= '0;
          rptr <= '0;
        end else begin
          cnt <= cnt + OW'(push) - OW'(pop);
          if (pop) rptr <= nxt(rptr);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sp_channel.sv
module sp_channel
  import span_prof_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter bit USE_BRAM = 1'b1,
  parameter int TOT_W    = 64,
  parameter int ERR_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [TS_W-1:0]  now,
  input  logic             start,
  input  logic             done,
  input  logic             pop,
  output logic             head_valid,
  output span_rec_t        head,
  output logic [TOT_W-1:0] total,
  output logic [ERR_W-1:0] err_cnt,
  output logic             ovf
);
  logic              open_q;
  logic [TS_W-1:0]   t_open_q;
  logic [ITER_W-1:0] iter_q;
  logic              closing;
  logic              buf_full;
  logic [TS_W-1:0]   span_len;
  span_rec_t         rec;

  assign closing  = done && open_q;
  assign span_len = now - t_open_q;
  assign rec      = '{iter: iter_q, t_start: t_open_q, t_end: now};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      open_q   <= 1'b0;
      t_open_q <= '0;
      iter_q   <= '0;
      total    <= '0;
      err_cnt  <= '0;
      ovf      <= 1'b0;
    end else begin
      if (closing) begin
        iter_q <= iter_q + 1'b1;
        total  <= total + TOT_W'(span_len);
        if (buf_full) ovf <= 1'b1;
      end
      if (start) begin
        open_q   <= 1'b1;
        t_open_q <= now;
        if (open_q && !done && (err_cnt != {ERR_W{1'b1}}))
          err_cnt <= err_cnt + 1'b1;
      end else if (closing) begin
        open_q <= 1'b0;
      end
    end
  end

  sp_fifo #(.DEPTH(DEPTH), .USE_BRAM(USE_BRAM)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .wr_en    (closing),
    .wr_data  (rec),
    .full     (buf_full),
    .rd_en    (pop),
    .rd_valid (head_valid),
    .rd_data  (head)
  );
endmodule

// File: rtl/sp_rr_arb.sv
module sp_rr_arb #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  int c;
  // scan from the highest offset down so the nearest request wins
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    c         = 0;
    for (int k = N - 1; k >= 0; k--) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (req[c]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(c);
      end
    end
  end
endmodule

// File: rtl/span_profiler.sv
module span_profiler
  import span_prof_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DEPTH    = 8,
  parameter bit USE_BRAM = 1'b1,
  parameter int TOT_W    = 64,
  parameter int ERR_W    = 8,
  localparam int CH_W    = idx_w(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [NCH-1:0]    start_i,
  input  logic [NCH-1:0]    done_i,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [CH_W-1:0]   rec_chan,
  output logic [ITER_W-1:0] rec_iter,
  output logic [TS_W-1:0]   rec_t_start,
  output logic [TS_W-1:0]   rec_t_end,
  input  logic [CH_W-1:0]   stat_sel,
  output logic [TOT_W-1:0]  stat_total,
  output logic [ERR_W-1:0]  stat_errs,
  output logic [NCH-1:0]    ovf_flags
);
  logic [TS_W-1:0]  cyc_now;
  logic [NCH-1:0]   head_v;
  logic [NCH-1:0]   pop;
  span_rec_t        heads  [NCH];
  logic [TOT_W-1:0] totals [NCH];
  logic [ERR_W-1:0] errs   [NCH];
  logic [CH_W-1:0]  rr_ptr;
  logic             gnt_valid;
  logic [CH_W-1:0]  gnt_idx;
  logic             take;

  sp_timebase u_time (.clk(clk), .rst(rst), .clr(clr), .now(cyc_now));

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      sp_channel #(
        .DEPTH(DEPTH), .USE_BRAM(USE_BRAM), .TOT_W(TOT_W), .ERR_W(ERR_W)
      ) u_ch (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .now        (cyc_now),
        .start      (start_i[g]),
        .done       (done_i[g]),
        .pop        (pop[g]),
        .head_valid (head_v[g]),
        .head       (heads[g]),
        .total      (totals[g]),
        .err_cnt    (errs[g]),
        .ovf        (ovf_flags[g])
      );
    end
  endgenerate

  sp_rr_arb #(.N(NCH), .IW(CH_W)) u_arb (
    .req       (head_v),
    .ptr       (rr_ptr),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign take = gnt_valid && (!rec_valid || rec_ready);

  always_comb begin
    pop = '0;
    if (take) pop[gnt_idx] = 1'b1;
  end

  // registered output stage of the read-out stream
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rec_valid   <= 1'b0;
      rec_chan    <= '0;
      rec_iter    <= '0;
      rec_t_start <= '0;
      rec_t_end   <= '0;
      rr_ptr      <= '0;
    end else if (take) begin
      rec_valid   <= 1'b1;
      rec_chan    <= gnt_idx;
      rec_iter    <= heads[gnt_idx].iter;
      rec_t_start <= heads[gnt_idx].t_start;
      rec_t_end   <= heads[gnt_idx].t_end;
      rr_ptr      <= (gnt_idx == CH_W'(NCH - 1)) ? '0 : gnt_idx + 1'b1;
    end else if (rec_ready) begin
      rec_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      stat_total <= '0;
      stat_errs  <= '0;
    end else if (int'(stat_sel) < NCH) begin
      stat_total <= totals[stat_sel];
      stat_errs  <= errs[stat_sel];
    end else begin
      stat_total <= '0;
      stat_errs  <= '0;
    end
  end
endmodule

// File: rtl/sp_checker.sv
module sp_checker
  import span_prof_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            clr,
  input logic            rec_valid,
  input logic            rec_ready,
  input logic [CH_W-1:0] rec_chan,
  input logic [ITER_W-1:0] rec_iter,
  input logic [TS_W-1:0] rec_t_start,
  input logic [TS_W-1:0] rec_t_end,
  input logic [NCH-1:0]  ovf_flags,
  input logic [TS_W-1:0] cyc_now
);
  p_tick_r1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cyc_now == TS_W'($past(cyc_now) + 1'b1));

  p_clear_time_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> cyc_now == '0);

  p_chan_range_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> int'(rec_chan) < NCH);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (ovf_flags & $past(ovf_flags)) == $past(ovf_flags));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !clr) |=> rec_valid && $stable(rec_chan) &&
      $stable(rec_iter) && $stable(rec_t_start) && $stable(rec_t_end));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !rec_valid && ovf_flags == '0);
endmodule

bind span_profiler sp_checker #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clr         (clr),
  .rec_valid   (rec_valid),
  .rec_ready   (rec_ready),
  .rec_chan    (rec_chan),
  .rec_iter    (rec_iter),
  .rec_t_start (rec_t_start),
  .rec_t_end   (rec_t_end),
  .ovf_flags   (ovf_flags),
  .cyc_now     (cyc_now)
);

// File: tb/test_span_profiler.sv
`timescale 1ns/1ps
module test_span_profiler;
  import span_prof_pkg::*;
  localparam int NCH = 3, DEPTH = 4, CH_W = 2, TOT_W = 64, ERR_W = 8;

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, rdy = 1'b0;
  logic [NCH-1:0] st = '0, dn = '0;
  logic [CH_W-1:0] sel = '0;

  logic va, vb;
  logic [CH_W-1:0] ca, cb;
  logic [ITER_W-1:0] ia, ib;
  logic [TS_W-1:0] sa, sb, ea, eb;
  logic [TOT_W-1:0] tota, totb;
  logic [ERR_W-1:0] erra, errb;
  logic [NCH-1:0] ovfa, ovfb;

  always #10 clk = ~clk;

  span_profiler #(.NCH(NCH), .DEPTH(DEPTH), .USE_BRAM(1'b1)) i_span_profiler (
    .clk(clk), .rst(rst), .clr(clr), .start_i(st), .done_i(dn),
    .rec_valid(va), .rec_ready(rdy), .rec_chan(ca), .rec_iter(ia),
    .rec_t_start(sa), .rec_t_end(ea), .stat_sel(sel),
    .stat_total(tota), .stat_errs(erra), .ovf_flags(ovfa));

  span_profiler #(.NCH(NCH), .DEPTH(DEPTH), .USE_BRAM(1'b0)) i_span_profiler_regs (
    .clk(clk), .rst(rst), .clr(clr), .start_i(st), .done_i(dn),
    .rec_valid(vb), .rec_ready(rdy), .rec_chan(cb), .rec_iter(ib),
    .rec_t_start(sb), .rec_t_end(eb), .stat_sel(sel),
    .stat_total(totb), .stat_errs(errb), .ovf_flags(ovfb));

  typedef struct { longint it; longint s; longint e; } ev_t;
  ev_t expq [NCH][$];
  ev_t gota [NCH][$];
  ev_t gotb [NCH][$];
  int  orda [$];
  int  ordb [$];

  bit     mopen [NCH];
  longint mts [NCH], miter [NCH], mtot [NCH], merr [NCH];
  longint tnow;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always @(posedge clk) if (rst || clr) tnow <= 0; else tnow <= tnow + 1;

  always @(negedge clk) begin
    if (!rst && !clr && rdy && va) begin
      gota[ca].push_back('{it: ia, s: sa, e: ea}); orda.push_back(int'(ca));
    end
    if (!rst && !clr && rdy && vb) begin
      gotb[cb].push_back('{it: ib, s: sb, e: eb}); ordb.push_back(int'(cb));
    end
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      mopen[c] = 0; mts[c] = 0; miter[c] = 0; mtot[c] = 0; merr[c] = 0;
      expq[c].delete(); gota[c].delete(); gotb[c].delete();
    end
    orda.delete(); ordb.delete();
  endtask

  task automatic pulse(logic [NCH-1:0] s, logic [NCH-1:0] d);
    for (int c = 0; c < NCH; c++) begin
      bit closing;
      closing = d[c] && mopen[c];
      if (closing) begin
        expq[c].push_back('{it: miter[c], s: mts[c], e: tnow});
        miter[c]++; mtot[c] += tnow - mts[c];
      end
      if (s[c]) begin
        if (mopen[c] && !d[c]) merr[c]++;
        mopen[c] = 1; mts[c] = tnow;
      end else if (closing) mopen[c] = 0;
    end
    st = s; dn = d;
    tick();
    st = '0; dn = '0;
  endtask

  task automatic span(int c, int len);
    pulse(NCH'(1 << c), '0);
    if (len > 1) tick(len - 1);
    pulse('0, NCH'(1 << c));
  endtask

  task automatic do_clear();
    clr = 1'b1;
    tick();
    clr = 1'b0;
    model_reset();
  endtask

  task automatic compare_all(string req);
    for (int c = 0; c < NCH; c++) begin
      check(req, $sformatf("ch%0d record count", c), gota[c].size(), expq[c].size());
      check("R10", $sformatf("ch%0d reg-mode count", c), gotb[c].size(), expq[c].size());
      for (int i = 0; i < expq[c].size(); i++) begin
        if (i < gota[c].size()) begin
          check("R2", $sformatf("ch%0d #%0d iter", c, i), gota[c][i].it, expq[c][i].it);
          check("R1", $sformatf("ch%0d #%0d start", c, i), gota[c][i].s, expq[c][i].s);
          check("R1", $sformatf("ch%0d #%0d end", c, i), gota[c][i].e, expq[c][i].e);
        end
        if (i < gotb[c].size()) begin
          check("R10", $sformatf("ch%0d #%0d reg iter", c, i), gotb[c][i].it, expq[c][i].it);
          check("R10", $sformatf("ch%0d #%0d reg start", c, i), gotb[c][i].s, expq[c][i].s);
          check("R10", $sformatf("ch%0d #%0d reg end", c, i), gotb[c][i].e, expq[c][i].e);
        end
      end
      expq[c].delete(); gota[c].delete(); gotb[c].delete();
    end
    orda.delete(); ordb.delete();
  endtask

  task automatic stat_check(int c, string req);
    sel = CH_W'(c);
    tick(2);
    check(req, $sformatf("ch%0d total", c), longint'(tota), mtot[c]);
    check(req, $sformatf("ch%0d total reg-mode", c), longint'(totb), mtot[c]);
    check("R4", $sformatf("ch%0d error count", c), longint'(erra), merr[c]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    tick(3);
    rst = 1'b0;
    check("R9", "reset valid", va, 0);
    check("R9", "reset ovf", ovfa, 0);
    check("R9", "reset total", tota, 0);

    // R2 / R1: sweep span lengths on every channel with the stream open
    rdy = 1'b1;
    for (int c = 0; c < NCH; c++)
      for (int len = 1; len <= 5; len++) begin
        span(c, len);
        check("R1", $sformatf("ch%0d span length", c),
              expq[c][expq[c].size()-1].e - expq[c][expq[c].size()-1].s, len);
        tick(2);
      end
    // overlapping spans on all channels
    for (int r = 0; r < 3; r++) begin
      pulse('1, '0); tick(1);
      pulse('0, 3'b001); tick(r);
      pulse('0, 3'b100); tick(1);
      pulse('0, 3'b010); tick(2);
    end
    tick(10);
    for (int c = 0; c < NCH; c++) stat_check(c, "R8");
    compare_all("R2");

    // R5: done without open span is ignored
    pulse('0, 3'b010); tick(8);
    check("R5", "stray done record count", gota[1].size(), 0);
    span(1, 3); tick(8);
    compare_all("R5");

    // R4: restart while open
    pulse(3'b100, '0); tick(3);
    pulse(3'b100, '0); tick(2);
    pulse('0, 3'b100); tick(8);
    compare_all("R4");
    stat_check(2, "R4");

    // R11: start and done together on an open span
    pulse(3'b001, '0); tick(3);
    pulse(3'b001, 3'b001); tick(2);
    pulse('0, 3'b001); tick(8);
    check("R11", "back-to-back count", expq[0].size(), 2);
    compare_all("R11");
    stat_check(0, "R11");

    // R7 / R6: round-robin drain after clear, output held while stalled
    rdy = 1'b0;
    do_clear();
    pulse('1, '0); tick(2); pulse('0, '1); tick(3);
    pulse('1, '0); tick(2); pulse('0, '1); tick(6);
    check("R7", "first channel after clear", ca, 0);
    check("R7", "first channel after clear reg-mode", cb, 0);
    begin
      longint held;
      held = longint'(ea);
      tick(4);
      check("R6", "valid held", va, 1);
      check("R6", "end held", longint'(ea), held);
    end
    rdy = 1'b1;
    tick(12);
    check("R7", "drain length", orda.size(), 6);
    for (int i = 0; i < 6; i++) begin
      if (i < orda.size()) check("R7", $sformatf("order slot %0d", i), orda[i], i % 3);
      if (i < ordb.size()) check("R7", $sformatf("order slot %0d reg-mode", i), ordb[i], i % 3);
    end
    compare_all("R7");

    // R3: overflow with a stalled stream, timestamps restart at zero (R1)
    rdy = 1'b0;
    do_clear();
    for (int k = 0; k < 6; k++) begin
      span(0, 2); tick(4);
    end
    check("R3", "ovf set", ovfa, 1);
    check("R3", "ovf set reg-mode", ovfb, 1);
    rdy = 1'b1;
    tick(12);
    if (gota[0].size() > 0) check("R1", "first stamp after clear", gota[0][0].s, 0);
    expq[0].delete(5);
    stat_check(0, "R3");
    compare_all("R3");
    check("R3", "ovf sticky", ovfa, 1);

    // R9: clear wipes everything
    do_clear();
    sel = '0;
    tick(2);
    check("R9", "clear ovf", ovfa, 0);
    check("R9", "clear valid", va, 0);
    check("R9", "clear total", tota, 0);
    check("R9", "clear errs", erra, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule